// File: doc/BRIEF.md
# Mode-Decoded Serial Command Slave

This block is the device-side serial port of a 32-channel converter array. A host frames each command with an active-low `sync_n`, clocks it with `sclk` and presents data on `din`, most significant bit first. The first two bits of every frame are a mode code, and the mode code sets both the frame length and the action. A command can load a 14-bit code into one channel register. It can load every channel register at once. It can raise an acquire request toward the analog side. It can also arm a readback, in which a later framed transfer returns the addressed register on `dout`. During that transfer `dout_en` drives an external tri-state pad.

The block holds 33 registers of 14 bits: channels 0 to 31, plus a separate offset-channel register. The serial pins are sampled on the system clock `clk`, which must run well above the serial bit rate. Edges of `sclk` and `sync_n` are found by comparing successive samples. A state machine has five states. `ST_IDLE` is the state after reset. `ST_HEAD` collects the 10-bit header. `ST_DATA` collects 14 data bits, in load mode only. `ST_READ` shifts out a readback. `ST_DONE` ignores `sclk` until the next frame. The transitions are as follows. `ST_IDLE` and `ST_DONE` go to `ST_READ` on a `sync_n` fall when a readback is armed, and to `ST_HEAD` on a `sync_n` fall otherwise. `ST_HEAD` goes to `ST_DATA` on its 10th bit in load mode, and to `ST_DONE` on its 10th bit in any other mode. `ST_DATA` goes to `ST_DONE` on its 14th bit. `ST_READ` goes to `ST_DONE` on the 14th counted falling `sclk` edge.

Top module: `dac_serial_slave`

## Requirements
- R1: After reset, all 33 registers read back as zero, `dout_en` is 0 and `acq_req` is 0.
- R2: `din` is taken on falling `sclk` edges, beginning with the first falling edge after `sync_n` falls. The header is 10 bits, sent first to last as mode[1], mode[0], cal, test, offset-select, then address bits A4 down to A0. Mode 00 is acquire, 01 is load, 10 is acquire-then-readback and 11 is readback.
- R3: A mode 01 frame is 24 bits long: the header, then data bits DB13 down to DB0. If cal is 0, it writes the data to the addressed channel. If offset-select is 1, it writes the offset register and the address bits have no effect.
- R4: A mode 01 frame with cal set to 1 writes all 32 channel registers together. All bits become 1 if DB13 is 1, and all bits become 0 if DB13 is 0. The offset register keeps its value.
- R5: A mode 00 frame is 10 bits long. It gives a one-cycle `acq_req` pulse, with `acq_all` equal to cal, `acq_offset` equal to offset-select, and `acq_addr` equal to the address. It changes no register.
- R6: After a mode 11 frame, the next `sync_n`-framed transfer returns the addressed register, DB13 first. `dout_en` rises after the first rising `sclk` edge. `dout` moves to the next bit on each following rising edge. `dout_en` falls after the 14th falling edge.
- R7: A mode 10 frame gives an `acq_req` pulse as in R5 and arms a readback as in R6. While `acquire_busy` is 1, rising and falling `sclk` edges of the readback transfer are not counted and `dout_en` stays 0. Once `acquire_busy` clears, the 14 bits follow.
- R8: A frame whose test bit is 1 still has the length its mode gives. It writes no register, gives no `acq_req` pulse and arms no readback.
- R9: Rising or falling `sync_n` edges inside a frame do not affect it. Once a frame is complete, extra `sclk` pulses are ignored until `sync_n` falls again.
- R10: `din` has no effect during a readback transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial bit clock |
| din | input | 1 | Serial command data, MSB first |
| acquire_busy | input | 1 | High while the analog side is acquiring |
| dout | output | 1 | Readback data bit |
| dout_en | output | 1 | Drive enable for the external `dout` pad |
| acq_req | output | 1 | One-cycle acquire request |
| acq_all | output | 1 | Acquire request targets all channels |
| acq_offset | output | 1 | Acquire request targets the offset channel |
| acq_addr | output | 5 | Channel address of the acquire request |

## Verification
The main stimulus is a sweep that loads a distinct, arithmetically derived code into every channel and into the offset register, then reads each one back. A wrong address decode, a wrong bit order or a wrong frame length shows up as a value mismatch on a specific channel. The bulk-load pattern is tried with the DB13 bit set and with it clear. This separates replication of DB13 from plain data, and shows whether the offset register is touched. Frames are also sent with extra `sclk` pulses, with a `sync_n` toggle in the middle, with the test bit set, and with a toggling `din` during reads. Each of these must leave the register contents and the acquire count exactly where the rules predict. A readback held by `acquire_busy` checks that edges are not counted before the hold releases.

// File: rtl/dss_pkg.sv
package dss_pkg;
    localparam int HDR_W  = 10;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_DATA,
        ST_READ,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        MD_ACQ   = 2'b00,
        MD_LOAD  = 2'b01,
        MD_ACQRD = 2'b10,
        MD_READ  = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0]        mode;
        logic              cal;
        logic              test;
        logic              offs;
        logic [ADDR_W-1:0] addr;
    } hdr_t;
endpackage

// File: rtl/dss_edge_detect.sv
module dss_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic sclk,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sync_fall,
    output logic din_s
);
    logic sclk_q, sclk_d, sync_q, sync_d, din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            sclk_d <= 1'b1;
            sync_q <= 1'b1;
            sync_d <= 1'b1;
            din_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sclk_d <= sclk_q;
            sync_q <= sync_n;
            sync_d <= sync_q;
            din_q  <= din;
        end
    end

    assign sclk_rise = sclk_q & ~sclk_d;
    assign sclk_fall = ~sclk_q & sclk_d;
    assign sync_fall = ~sync_q & sync_d;
    assign din_s     = din_q;
endmodule

// File: rtl/dss_regfile.sv
module dss_regfile #(
    parameter int NCH = 32,
    parameter int DW  = 14,
    localparam int IW = $clog2(NCH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          wall,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NCH+1];

    for (genvar g = 0; g <= NCH; g++) begin : g_entry
        localparam bit IS_CH = (g < NCH);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if ((wall && IS_CH) || (we && waddr == IW'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

    // R4: a bulk load never disturbs the offset register
    assert_offset_kept_on_bulk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wall |=> mem[NCH] == $past(mem[NCH]));
endmodule

// File: rtl/dss_rb_shift.sv
module dss_rb_shift #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic          stop,
    input  logic [DW-1:0] word,
    output logic          dout,
    output logic          dout_en
);
    logic [DW-1:0] sh_q;
    logic          en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            en_q <= 1'b0;
        end else if (load) begin
            sh_q <= word;
            en_q <= 1'b1;
        end else begin
            if (shift) sh_q <= {sh_q[DW-2:0], 1'b0};
            if (stop)  en_q <= 1'b0;
        end
    end

    assign dout    = sh_q[DW-1];
    assign dout_en = en_q;

    // R6: the pad enable is released only by the end-of-word stop
    assert_en_release_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> $past(stop));
    // R6: shifting happens only while the pad is driven
    assert_shift_while_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> en_q);
endmodule

// File: rtl/dss_frame_ctrl.sv
module dss_frame_ctrl
    import dss_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 14,
    localparam int IW = $clog2(NCH + 1),
    localparam int CW = $clog2(DW) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sync_fall,
    input  logic              din_s,
    input  logic              acquire_busy,
    output logic              we_o,
    output logic              wall_o,
    output logic [IW-1:0]     waddr_o,
    output logic [DW-1:0]     wdata_o,
    output logic [IW-1:0]     ridx_o,
    output logic              rb_load_o,
    output logic              rb_shift_o,
    output logic              rb_stop_o,
    output logic              acq_req_o,
    output logic              acq_all_o,
    output logic              acq_offset_o,
    output logic [ADDR_W-1:0] acq_addr_o
);
    state_e            state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [HDR_W-2:0]  sh_q;
    logic [DW-2:0]     dat_q;
    hdr_t              hdr_q, hdr_now;
    logic              arm_q, arm_acq_q, started_q;
    logic [IW-1:0]     arm_idx_q;
    logic              hold, last_hdr, last_dat, last_rd;
    logic [IW-1:0]     idx_now;

    assign hdr_now  = hdr_t'({sh_q, din_s});
    assign idx_now  = hdr_now.offs ? IW'(NCH) : IW'(hdr_now.addr);
    assign last_hdr = sclk_fall && cnt_q == CW'(HDR_W - 1);
    assign last_dat = sclk_fall && cnt_q == CW'(DW - 1);
    assign hold     = arm_acq_q && acquire_busy;
    assign last_rd  = sclk_fall && started_q && cnt_q == CW'(DW - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (sync_fall) state_d = arm_q ? ST_READ : ST_HEAD;
            ST_HEAD: if (last_hdr) state_d = (hdr_now.mode == MD_LOAD) ? ST_DATA : ST_DONE;
            ST_DATA: if (last_dat) state_d = ST_DONE;
            ST_READ: if (last_rd)  state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    // readback strobes
    assign rb_load_o  = (state_q == ST_READ) && sclk_rise && !started_q && !hold;
    assign rb_shift_o = (state_q == ST_READ) && sclk_rise && started_q;
    assign rb_stop_o  = (state_q == ST_READ) && last_rd;
    assign ridx_o     = arm_idx_q;

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            sh_q         <= '0;
            dat_q        <= '0;
            hdr_q        <= '0;
            arm_q        <= 1'b0;
            arm_acq_q    <= 1'b0;
            arm_idx_q    <= '0;
            started_q    <= 1'b0;
            we_o         <= 1'b0;
            wall_o       <= 1'b0;
            waddr_o      <= '0;
            wdata_o      <= '0;
            acq_req_o    <= 1'b0;
            acq_all_o    <= 1'b0;
            acq_offset_o <= 1'b0;
            acq_addr_o   <= '0;
        end else begin
            we_o      <= 1'b0;
            wall_o    <= 1'b0;
            acq_req_o <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (sync_fall) begin
                        cnt_q     <= '0;
                        started_q <= 1'b0;
                    end
                end
                ST_HEAD: begin
                    if (sclk_fall) begin
                        sh_q  <= {sh_q[HDR_W-3:0], din_s};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (last_hdr) begin
                        hdr_q <= hdr_now;
                        cnt_q <= '0;
                        if (!hdr_now.test && hdr_now.mode != MD_LOAD) begin
                            if (hdr_now.mode != MD_READ) begin
                                acq_req_o    <= 1'b1;
                                acq_all_o    <= hdr_now.cal;
                                acq_offset_o <= hdr_now.offs;
                                acq_addr_o   <= hdr_now.addr;
                            end
                            if (hdr_now.mode != MD_ACQ) begin
                                arm_q     <= 1'b1;
                                arm_acq_q <= (hdr_now.mode == MD_ACQRD);
                                arm_idx_q <= idx_now;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (sclk_fall) begin
                        dat_q <= {dat_q[DW-3:0], din_s};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (last_dat && !hdr_q.test) begin
                        if (hdr_q.cal) begin
                            wall_o  <= 1'b1;
                            wdata_o <= {DW{dat_q[DW-2]}};
                        end else begin
                            we_o    <= 1'b1;
                            wdata_o <= {dat_q, din_s};
                            waddr_o <= hdr_q.offs ? IW'(NCH) : IW'(hdr_q.addr);
                        end
                    end
                end
                ST_READ: begin
                    if (rb_load_o) started_q <= 1'b1;
                    if (sclk_fall && started_q) cnt_q <= cnt_q + 1'b1;
                    if (last_rd) arm_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R5: an acquire request lasts one cycle
    assert_acq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acq_req_o |=> !acq_req_o);
    // R5: an acquire request follows the end of a header
    assert_acq_after_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acq_req_o |-> $past(state_q) == ST_HEAD);
    // R8: no acquire request from a header with the test bit set
    assert_acq_test_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acq_req_o |-> !hdr_q.test);
    // R3: register writes only complete a data phase
    assert_write_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o || wall_o) |-> $past(state_q) == ST_DATA);
    // R10: readback never writes a register
    assert_no_write_in_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_READ |-> !(we_o || wall_o));
    // R7: the word is not loaded while the acquisition is running
    assert_hold_blocks_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !rb_load_o);
endmodule

// File: rtl/dac_serial_slave.sv
module dac_serial_slave
    import dss_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              acquire_busy,
    output logic              dout,
    output logic              dout_en,
    output logic              acq_req,
    output logic              acq_all,
    output logic              acq_offset,
    output logic [ADDR_W-1:0] acq_addr
);
    localparam int IW = $clog2(NCH + 1);

    logic          sclk_rise, sclk_fall, sync_fall, din_s;
    logic          we, wall, rb_load, rb_shift, rb_stop;
    logic [IW-1:0] waddr, ridx;
    logic [DW-1:0] wdata, rdata;

    dss_edge_detect u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .sclk      (sclk),
        .din       (din),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sync_fall (sync_fall),
        .din_s     (din_s)
    );

    dss_frame_ctrl #(.NCH(NCH), .DW(DW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_rise    (sclk_rise),
        .sclk_fall    (sclk_fall),
        .sync_fall    (sync_fall),
        .din_s        (din_s),
        .acquire_busy (acquire_busy),
        .we_o         (we),
        .wall_o       (wall),
        .waddr_o      (waddr),
        .wdata_o      (wdata),
        .ridx_o       (ridx),
        .rb_load_o    (rb_load),
        .rb_shift_o   (rb_shift),
        .rb_stop_o    (rb_stop),
        .acq_req_o    (acq_req),
        .acq_all_o    (acq_all),
        .acq_offset_o (acq_offset),
        .acq_addr_o   (acq_addr)
    );

    dss_regfile #(.NCH(NCH), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wall  (wall),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (ridx),
        .rdata (rdata)
    );

    dss_rb_shift #(.DW(DW)) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rb_load),
        .shift   (rb_shift),
        .stop    (rb_stop),
        .word    (rdata),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // R6: the pad is never driven while the acquire request fires
    assert_no_drive_on_acq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acq_req |-> !dout_en);
endmodule

// File: tb/dac_serial_slave_bench.sv
module dac_serial_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1, sclk = 1'b1, din = 1'b0, acquire_busy = 1'b0;
    logic       dout, dout_en, acq_req, acq_all, acq_offset;
    logic [4:0] acq_addr;

    int  n_tests = 0, n_fail = 0, acq_cnt = 0;
    bit  en_seen = 1'b0, done = 1'b0;
    logic [4:0] last_addr;
    logic last_all, last_offs;

    always #10 clk = ~clk;

    dac_serial_slave u_dac_serial_slave (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
        .acquire_busy(acquire_busy), .dout(dout), .dout_en(dout_en),
        .acq_req(acq_req), .acq_all(acq_all), .acq_offset(acq_offset),
        .acq_addr(acq_addr)
    );

    always @(posedge clk) begin
        if (acq_req) begin
            acq_cnt   <= acq_cnt + 1;
            last_addr <= acq_addr;
            last_all  <= acq_all;
            last_offs <= acq_offset;
        end
        if (dout_en) en_seen <= 1'b1;
    end

    function automatic logic [13:0] val(int ch);
        return 14'((ch * 613 + 97) & 16'h3FFF);
    endfunction

    function automatic logic [9:0] hdr(logic [1:0] m, logic cal, logic tst,
                                       logic offs, logic [4:0] a);
        return {m, cal, tst, offs, a};
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // sends the low n bits of w; mid >= 0 toggles sync_n before that bit
    task automatic send(int n, logic [23:0] w, int extra, int mid);
        sync_n = 1'b0; tick(4);
        for (int i = 0; i < n + extra; i++) begin
            if (i == mid) begin
                sync_n = 1'b1; tick(4); sync_n = 1'b0; tick(4);
            end
            din = (i < n) ? w[n-1-i] : 1'b1;
            sclk = 1'b0; tick(4);
            sclk = 1'b1; tick(4);
        end
        sync_n = 1'b1; tick(4);
    endtask

    task automatic read_word(int held, output logic [13:0] v, output bit en_ok);
        en_ok = 1'b1;
        v = '0;
        sync_n = 1'b0; tick(4);
        for (int i = 0; i < held; i++) begin
            sclk = 1'b0; tick(4);
            sclk = 1'b1; tick(4);
            if (dout_en) en_ok = 1'b0;
        end
        acquire_busy = 1'b0; tick(4);
        for (int i = 0; i < 14; i++) begin
            din = ~din;
            sclk = 1'b0; tick(4);
            sclk = 1'b1; tick(4);
            if (!dout_en) en_ok = 1'b0;
            v[13-i] = dout;
        end
        sclk = 1'b0; tick(4);
        if (dout_en) en_ok = 1'b0;
        sclk = 1'b1; sync_n = 1'b1; tick(4);
    endtask

    task automatic rd(int idx, output logic [13:0] v, output bit en_ok);
        if (idx == 32) send(10, {14'h0, hdr(2'b11, 0, 0, 1, 5'd5)}, 0, -1);
        else           send(10, {14'h0, hdr(2'b11, 0, 0, 0, 5'(idx))}, 0, -1);
        read_word(0, v, en_ok);
    endtask

    task automatic wr(int ch, logic [13:0] d, int extra, int mid);
        send(24, {hdr(2'b01, 0, 0, 0, 5'(ch)), d}, extra, mid);
    endtask

    initial begin
        logic [13:0] v;
        bit en_ok;
        int c0;
        tick(3); rst_n = 1'b1; tick(3);

        // R1: reset state
        check(dout_en == 1'b0, "R1 dout_en", dout_en, 0);
        check(acq_req == 1'b0, "R1 acq_req", acq_req, 0);
        rd(20, v, en_ok);
        check(v == 14'h0, "R1 ch20 reset", v, 0);

        // R2 R3: load all channels, offset via offset-select with address ignored
        for (int ch = 0; ch < 32; ch++) wr(ch, val(ch), 0, -1);
        send(24, {hdr(2'b01, 0, 0, 1, 5'd21), val(32)}, 0, -1);
        for (int ch = 0; ch <= 32; ch++) begin
            rd(ch, v, en_ok);
            check(v == val(ch), $sformatf("R3 R6 readback ch%0d", ch), v, val(ch));
            check(en_ok, $sformatf("R6 dout_en window ch%0d", ch), en_ok, 1);
        end

        // R5: acquire frame, then extra clocks ignored (R9)
        c0 = acq_cnt;
        send(10, {14'h0, hdr(2'b00, 0, 0, 0, 5'd9)}, 3, -1);
        tick(2);
        check(acq_cnt == c0 + 1, "R5 R9 single acq", acq_cnt, c0 + 1);
        check(last_addr == 5'd9 && !last_all && !last_offs, "R5 acq fields", last_addr, 9);
        send(10, {14'h0, hdr(2'b00, 1, 0, 1, 5'd3)}, 0, -1);
        tick(2);
        check(last_all && last_offs, "R5 acq all/offset", {last_all, last_offs}, 3);
        rd(9, v, en_ok);
        check(v == val(9), "R5 no reg change", v, val(9));

        // R8: test bit set discards frames
        send(24, {hdr(2'b01, 0, 1, 0, 5'd3), 14'h1234}, 0, -1);
        rd(3, v, en_ok);
        check(v == val(3), "R8 load discarded", v, val(3));
        c0 = acq_cnt;
        send(10, {14'h0, hdr(2'b00, 0, 1, 0, 5'd4)}, 0, -1);
        tick(2);
        check(acq_cnt == c0, "R8 acq discarded", acq_cnt, c0);
        send(10, {14'h0, hdr(2'b11, 0, 1, 0, 5'd4)}, 0, -1);
        en_seen = 1'b0;
        wr(4, 14'h2AAA, 0, -1);
        check(!en_seen, "R8 readback not armed", en_seen, 0);
        rd(4, v, en_ok);
        check(v == 14'h2AAA, "R8 next frame is command", v, 14'h2AAA);

        // R9: sync toggled mid-frame, extra clocks after a load
        wr(6, 14'h0F0F, 0, 7);
        rd(6, v, en_ok);
        check(v == 14'h0F0F, "R9 mid-frame sync ignored", v, 14'h0F0F);
        wr(7, 14'h1111, 5, -1);
        rd(7, v, en_ok);
        check(v == 14'h1111, "R9 extra clocks ch7", v, 14'h1111);
        rd(8, v, en_ok);
        check(v == val(8), "R9 extra clocks ch8 intact", v, val(8));

        // R7: acquire then readback held by acquire_busy
        acquire_busy = 1'b1;
        c0 = acq_cnt;
        send(10, {14'h0, hdr(2'b10, 0, 0, 0, 5'd12)}, 0, -1);
        tick(2);
        check(acq_cnt == c0 + 1 && last_addr == 5'd12, "R7 acq issued", acq_cnt, c0 + 1);
        read_word(3, v, en_ok);
        check(v == val(12), "R7 R10 held readback", v, val(12));
        check(en_ok, "R7 tri-state while busy", en_ok, 1);

        // R4: bulk loads
        send(24, {hdr(2'b01, 1, 0, 0, 5'd0), 14'h2000}, 0, -1);
        rd(0, v, en_ok);
        check(v == 14'h3FFF, "R4 bulk ones ch0", v, 14'h3FFF);
        rd(31, v, en_ok);
        check(v == 14'h3FFF, "R4 bulk ones ch31", v, 14'h3FFF);
        rd(32, v, en_ok);
        check(v == val(32), "R4 offset kept", v, val(32));
        send(24, {hdr(2'b01, 1, 0, 0, 5'd0), 14'h1FFF}, 0, -1);
        rd(17, v, en_ok);
        check(v == 14'h0, "R4 bulk zeros ch17", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule